// File: doc/BRIEF.md
# Interrupt aggregation and wake-up controller

This block gathers the interrupt sources of a small 8-bit microcontroller into one interrupt request for the core. It also produces a wake-up request for the core while it sleeps. There are three core-level sources:

- an external pin that triggers on an edge the software chooses;
- a timer rollover pulse;
- a port-change pulse.

A parameterised set of peripheral event lines makes up a second group. Each source has a sticky flag and an enable. The peripheral group also passes through a group enable, and a master enable gates the whole request.

Wake-up is decided on a different basis. While the core sleeps, any flag whose own enable is set raises a one-cycle wake pulse. Neither the master enable nor the group enable takes part in that decision. The master enable only tells the core, through a separate output, whether to branch to the fixed vector after it wakes.

The core reads and writes four small registers over a simple synchronous write port and a combinational read port. The timer, the port logic and the peripherals sit outside the block and arrive as one-cycle event pulses.

Top module: `irqw_top`

## Requirements
- R1: After reset, all four registers read 0, `irq_o` and `wake_o` are low, and `vec_o` equals 0x0004.
- R2: Register map. Address 0 is control: bit0 master enable, bit1 peripheral group enable, bit2 pin enable, bit3 timer enable, bit4 change enable, bit5 pin flag, bit6 timer flag, bit7 change flag. Address 1 holds the peripheral enables, address 2 the peripheral flags and address 3 the configuration. A write stores `wr_data` at the next clock edge, and reads are combinational.
- R3: The pin passes through two synchronising flops. Configuration bit0 set selects a rising edge and clear selects a falling edge. A selected edge sets the pin flag by the third clock edge after the pin changes. An edge of the other polarity leaves the flag clear.
- R4: A one-cycle `tmr_ovf_i` pulse sets control bit6 at the next clock edge.
- R5: A one-cycle `port_chg_i` pulse sets control bit7 at the next clock edge.
- R6: A pulse on `periph_evt_i[k]` sets bit k of the peripheral flag register at the next clock edge.
- R7: Flags are sticky. A flag keeps its value until a write to its register changes it.
- R8: When a software write clears a flag in the same cycle that its set event arrives, the flag ends up set.
- R9: `irq_o` is high when the master enable is set and either condition holds: some core flag and its enable are both set, or the group enable is set and some peripheral flag and its enable are both set. Clearing an enable removes that source's contribution.
- R10: A wake condition exists when `sleep_i` is high and any flag has its own enable set, whatever the master and group enables hold. `wake_o` pulses for exactly one cycle when that condition first becomes true.
- R11: `wake_vec_o` equals `wake_o` AND the master enable. It tells the core whether to branch to `vec_o` after waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf_i | input | 1 | Timer rollover pulse |
| port_chg_i | input | 1 | Port-change pulse |
| periph_evt_i | input | NPERIPH | Peripheral event pulses |
| sleep_i | input | 1 | Core is in sleep mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Read data |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | One-cycle wake-up pulse |
| wake_vec_o | output | 1 | Branch to vector after this wake-up |
| vec_o | output | VEC_W | Interrupt vector address |

## Verification
A software write that clears a flag can land in the same clock cycle as a new hardware set event for that flag. The bench provokes this by driving a control or peripheral-flag write of zero together with a timer or peripheral pulse in a single cycle. It then reads the register back and expects the bit to be set, since the event must not be lost. A second collision is between the wake decision and the master enable. The bench raises the same timer flag during sleep with the master enable off and then on. It expects an identical wake pulse both times, with `wake_vec_o` following the master enable alone.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_PEN  = 2'd1,
      RA_PFLG = 2'd2,
      RA_CFG  = 2'd3
   } reg_addr_e;

   localparam int ADDR_W   = 2;
   localparam int NCORE    = 3;
   localparam int B_GIE    = 0;
   localparam int B_PEIE   = 1;
   localparam int B_EN0    = 2;  // pin, timer, change enables at 2..4
   localparam int B_FL0    = 5;  // pin, timer, change flags at 5..7
   localparam int B_RISE   = 0;
endpackage

// File: rtl/irqw_sync_edge.sv
module irqw_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic rise_sel_i,
   output logic hit_o
);
   localparam int LAST = STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("irqw_sync_edge: STAGES must be at least 2");
   end

   // chain[0..STAGES-1] synchronise, chain[STAGES] holds the previous sample
   logic [LAST:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[LAST-1:0], pin_i};
   end

   logic now_s, prev_s;
   assign now_s  = chain_q[LAST-1];
   assign prev_s = chain_q[LAST];

   always_comb begin
      if (rise_sel_i) hit_o = now_s & ~prev_s;
      else            hit_o = ~now_s & prev_s;
   end

   // R3: a hit always follows a change in the synchronised level
   p_hit_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (now_s != prev_s));
endmodule

// File: rtl/irqw_flag_cell.sv
module irqw_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wr_i,
   input  logic wd_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (wr_i)  q_o <= wd_i;
   end

   // R8: a set event always wins, even against a clearing write
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   // R7: the flag only drops after a write
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(q_o) |-> $past(wr_i));
endmodule

// File: rtl/irqw_combine.sv
module irqw_combine #(
   parameter int NCORE   = 3,
   parameter int NPERIPH = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               gie_i,
   input  logic               peie_i,
   input  logic [NCORE-1:0]   core_fl_i,
   input  logic [NCORE-1:0]   core_en_i,
   input  logic [NPERIPH-1:0] per_fl_i,
   input  logic [NPERIPH-1:0] per_en_i,
   input  logic               sleep_i,
   output logic               irq_o,
   output logic               wake_o
);
   logic core_any, per_any, wake_cond, wake_cond_q;

   assign core_any  = |(core_fl_i & core_en_i);
   assign per_any   = |(per_fl_i & per_en_i);
   assign irq_o     = gie_i & (core_any | (peie_i & per_any));
   assign wake_cond = sleep_i & (core_any | per_any);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_cond_q <= 1'b0;
      else        wake_cond_q <= wake_cond;
   end

   assign wake_o = wake_cond & ~wake_cond_q;

   // R9: no request without the master enable
   p_irq_needs_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> gie_i);
   // R10: wake is a single-cycle pulse, only during sleep
   p_wake_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |=> !wake_o);
   p_wake_in_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> sleep_i);
endmodule

// File: rtl/irqw_top.sv
module irqw_top
   import irqw_pkg::*;
#(
   parameter int               DATA_W      = 8,
   parameter int               NPERIPH     = 8,
   parameter int               SYNC_STAGES = 2,
   parameter int               VEC_W       = 13,
   parameter logic [VEC_W-1:0] VECTOR      = 13'h0004
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ext_pin_i,
   input  logic                 tmr_ovf_i,
   input  logic                 port_chg_i,
   input  logic [NPERIPH-1:0]   periph_evt_i,
   input  logic                 sleep_i,
   input  logic                 wr_en_i,
   input  logic [1:0]           wr_addr_i,
   input  logic [DATA_W-1:0]    wr_data_i,
   input  logic [1:0]           rd_addr_i,
   output logic [DATA_W-1:0]    rd_data_o,
   output logic                 irq_o,
   output logic                 wake_o,
   output logic                 wake_vec_o,
   output logic [VEC_W-1:0]     vec_o
);
   localparam int CTRL_BITS = B_FL0 + NCORE;

   if (DATA_W < CTRL_BITS) begin : g_bad_width
      $error("irqw_top: DATA_W too small for the control register");
   end
   if (NPERIPH < 1 || NPERIPH > DATA_W) begin : g_bad_periph
      $error("irqw_top: NPERIPH must be 1..DATA_W");
   end

   // ---------------- write decode ----------------
   logic wr_ctrl, wr_pen, wr_pflg, wr_cfg;
   assign wr_ctrl = wr_en_i && (wr_addr_i == RA_CTRL);
   assign wr_pen  = wr_en_i && (wr_addr_i == RA_PEN);
   assign wr_pflg = wr_en_i && (wr_addr_i == RA_PFLG);
   assign wr_cfg  = wr_en_i && (wr_addr_i == RA_CFG);

   // ---------------- enable and config registers ----------------
   logic               gie_q, peie_q, rise_q;
   logic [NCORE-1:0]   core_en_q;
   logic [NPERIPH-1:0] per_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q     <= 1'b0;
         peie_q    <= 1'b0;
         core_en_q <= '0;
      end else if (wr_ctrl) begin
         gie_q     <= wr_data_i[B_GIE];
         peie_q    <= wr_data_i[B_PEIE];
         core_en_q <= wr_data_i[B_EN0 +: NCORE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      per_en_q <= '0;
      else if (wr_pen) per_en_q <= wr_data_i[NPERIPH-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rise_q <= 1'b0;
      else if (wr_cfg) rise_q <= wr_data_i[B_RISE];
   end

   // ---------------- external pin edge ----------------
   logic ext_hit;
   irqw_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (ext_pin_i),
      .rise_sel_i (rise_q),
      .hit_o      (ext_hit)
   );

   // ---------------- flag cells ----------------
   logic [NCORE-1:0]   core_set, core_fl;
   logic [NPERIPH-1:0] per_fl;
   assign core_set = {port_chg_i, tmr_ovf_i, ext_hit};

   for (genvar i = 0; i < NCORE; i++) begin : g_core_flag
      irqw_flag_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (core_set[i]),
         .wr_i  (wr_ctrl),
         .wd_i  (wr_data_i[B_FL0 + i]),
         .q_o   (core_fl[i])
      );
   end

   for (genvar k = 0; k < NPERIPH; k++) begin : g_per_flag
      irqw_flag_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (periph_evt_i[k]),
         .wr_i  (wr_pflg),
         .wd_i  (wr_data_i[k]),
         .q_o   (per_fl[k])
      );
   end

   // ---------------- request and wake ----------------
   irqw_combine #(.NCORE(NCORE), .NPERIPH(NPERIPH)) u_comb (
      .clk       (clk),
      .rst_n     (rst_n),
      .gie_i     (gie_q),
      .peie_i    (peie_q),
      .core_fl_i (core_fl),
      .core_en_i (core_en_q),
      .per_fl_i  (per_fl),
      .per_en_i  (per_en_q),
      .sleep_i   (sleep_i),
      .irq_o     (irq_o),
      .wake_o    (wake_o)
   );

   assign wake_vec_o = wake_o & gie_q;
   assign vec_o      = VECTOR;

   // ---------------- read mux ----------------
   logic [DATA_W-1:0] ctrl_rd;
   always_comb begin
      ctrl_rd                    = '0;
      ctrl_rd[B_GIE]             = gie_q;
      ctrl_rd[B_PEIE]            = peie_q;
      ctrl_rd[B_EN0 +: NCORE]    = core_en_q;
      ctrl_rd[B_FL0 +: NCORE]    = core_fl;
   end

   always_comb begin
      unique case (rd_addr_i)
         RA_CTRL: rd_data_o = ctrl_rd;
         RA_PEN:  rd_data_o = DATA_W'(per_en_q);
         RA_PFLG: rd_data_o = DATA_W'(per_fl);
         default: rd_data_o = DATA_W'(rise_q);
      endcase
   end

   // R3: the pin flag rises only after a qualified edge or a write of 1
   p_ext_flag_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_fl[0]) |-> ($past(ext_hit) || $past(wr_ctrl && wr_data_i[B_FL0])));
   // R11: a vectored wake needs the master enable
   p_wake_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_vec_o |-> (wake_o && gie_q));
endmodule

// File: tb/tb_irqw_top.sv
module tb_irqw_top;
   localparam int DW = 8;
   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ext_pin = 1'b0, tmr_ovf = 1'b0, port_chg = 1'b0, sleep = 1'b0;
   logic [NP-1:0] pevt = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0, rd_data;
   logic          irq, wake, wake_vec;
   logic [12:0]   vec;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   irqw_top dut (
      .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .tmr_ovf_i(tmr_ovf),
      .port_chg_i(port_chg), .periph_evt_i(pevt), .sleep_i(sleep),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq),
      .wake_o(wake), .wake_vec_o(wake_vec), .vec_o(vec)
   );

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
      rd_addr = a;
      #0.1;
      d = rd_data;
   endtask

   task automatic clear_all();
      wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         chk("R1 reg", d, 0);
      end
      chk("R1 irq", irq, 0);
      chk("R1 wake", wake, 0);
      chk("R1 vec", vec, 13'h0004);
   endtask

   task automatic t_pin_rise();
      logic [DW-1:0] d;
      wr(2'd3, 8'h01);
      rd(2'd3, d); chk("R2 cfg readback", d, 1);
      @(negedge clk); ext_pin = 1'b1;
      repeat (3) @(negedge clk);
      rd(2'd0, d); chk("R3 rising edge sets pin flag", d[5], 1);
      chk("R9 no irq without enables", irq, 0);
      wr(2'd0, 8'h00);
      @(negedge clk); ext_pin = 1'b0;
      repeat (4) @(negedge clk);
      rd(2'd0, d); chk("R3 falling edge ignored in rising mode", d[5], 0);
   endtask

   task automatic t_pin_fall();
      logic [DW-1:0] d;
      wr(2'd3, 8'h00);
      @(negedge clk); ext_pin = 1'b1;
      repeat (4) @(negedge clk);
      rd(2'd0, d); chk("R3 rising edge ignored in falling mode", d[5], 0);
      @(negedge clk); ext_pin = 1'b0;
      repeat (3) @(negedge clk);
      rd(2'd0, d); chk("R3 falling edge sets pin flag", d[5], 1);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_timer_port();
      logic [DW-1:0] d;
      @(negedge clk); tmr_ovf = 1'b1;
      @(negedge clk); tmr_ovf = 1'b0;
      rd(2'd0, d); chk("R4 timer flag", d, 8'h40);
      @(negedge clk); port_chg = 1'b1;
      @(negedge clk); port_chg = 1'b0;
      rd(2'd0, d); chk("R5 change flag", d, 8'hC0);
      wr(2'd0, 8'h00);
      rd(2'd0, d); chk("R7 write clears flags", d, 0);
   endtask

   task automatic t_periph();
      logic [DW-1:0] d;
      @(negedge clk); pevt = 8'h05;
      @(negedge clk); pevt = 8'h00;
      rd(2'd2, d); chk("R6 peripheral flags", d, 8'h05);
      repeat (5) @(negedge clk);
      rd(2'd2, d); chk("R7 peripheral flags sticky", d, 8'h05);
      wr(2'd2, 8'h01);
      rd(2'd2, d); chk("R7 write stores value", d, 8'h01);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_collide();
      logic [DW-1:0] d;
      wr(2'd0, 8'h40);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h00; tmr_ovf = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; tmr_ovf = 1'b0;
      rd(2'd0, d); chk("R8 timer set beats clear", d[6], 1);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h00; pevt = 8'h80;
      @(negedge clk);
      wr_en = 1'b0; pevt = 8'h00;
      rd(2'd2, d); chk("R8 peripheral set beats clear", d, 8'h80);
      clear_all();
   endtask

   task automatic t_irq();
      wr(2'd0, 8'h09);
      @(negedge clk); tmr_ovf = 1'b1;
      @(negedge clk); tmr_ovf = 1'b0;
      chk("R9 enabled timer flag requests", irq, 1);
      wr(2'd0, 8'h48); #0.1;
      chk("R9 master enable off", irq, 0);
      wr(2'd0, 8'h41); #0.1;
      chk("R9 source enable off", irq, 0);
      wr(2'd0, 8'h01); wr(2'd1, 8'h02);
      @(negedge clk); pevt = 8'h02;
      @(negedge clk); pevt = 8'h00;
      chk("R9 peripheral without group enable", irq, 0);
      wr(2'd0, 8'h03); #0.1;
      chk("R9 peripheral with group enable", irq, 1);
      wr(2'd1, 8'h00); #0.1;
      chk("R9 peripheral enable off", irq, 0);
      clear_all();
   endtask

   task automatic t_wake();
      wr(2'd0, 8'h08);
      sleep = 1'b1;
      @(negedge clk); tmr_ovf = 1'b1;
      @(negedge clk); tmr_ovf = 1'b0;
      chk("R10 wake without master enable", wake, 1);
      chk("R11 no vector without master enable", wake_vec, 0);
      @(negedge clk);
      chk("R10 wake lasts one cycle", wake, 0);
      wr(2'd0, 8'h09);
      @(negedge clk); tmr_ovf = 1'b1;
      @(negedge clk); tmr_ovf = 1'b0;
      chk("R10 wake with master enable", wake, 1);
      chk("R11 vector with master enable", wake_vec, 1);
      clear_all();
      wr(2'd1, 8'h01);
      @(negedge clk); pevt = 8'h01;
      @(negedge clk); pevt = 8'h00;
      chk("R10 peripheral wake ignores group enable", wake, 1);
      clear_all();
      sleep = 1'b0;
      wr(2'd0, 8'h08);
      @(negedge clk); tmr_ovf = 1'b1;
      @(negedge clk); tmr_ovf = 1'b0;
      chk("R10 no wake when awake", wake, 0);
      clear_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pin_rise();
      t_pin_fall();
      t_timer_port();
      t_periph();
      t_collide();
      t_irq();
      t_wake();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule